// File: doc/BRIEF.md
# Mixed-Mode Burst Controller for Pseudo-Static RAM

This block sits on the host side of a pseudo-static RAM bus whose memory has already been set for synchronous operation. Reads go out as clocked bursts of 4, 8 or 16 words. Writes go out as single-word asynchronous cycles, with the memory clock held low for the whole cycle. The controller drives the memory clock, chip enable, address-valid strobe, write enable, output enable, address, byte enables and write data. The pads themselves are outside the block.

A shared, wired-OR WAIT line is active low and has an external pull-up. It paces each burst. A timing input selects how WAIT lines up with the real wait cycles. In aligned timing, a word is present at any rising memory clock edge where WAIT is inactive. In early timing, WAIT runs one edge ahead of the wait cycles, so a word is present at an edge only if WAIT was inactive at the previous edge of the burst. A timeout counter ends a burst that has stalled for too long.

A host starts an operation with a single-cycle request that carries the direction, address, burst length code, write data and byte mask. The host may issue a request whenever the ready output is high. Each word that a read returns is presented with a one-cycle valid strobe.

Top module: `psram_mixed_ctrl`

## Requirements
- R1: After reset, chip enable, address-valid, write enable and output enable are all high, the memory clock is low, ready is high, and read valid and timeout are both low.
- R2: A read drives chip enable and address-valid low for exactly one memory clock period of two controller cycles. The memory clock starts low in that period and then toggles every controller cycle while chip enable stays low. The request address appears on the address output, all byte enables are driven low, and output enable is low for the data phase.
- R3: A read returns exactly 4, 8 or 16 words for burst length codes 0, 1 and 2 respectively, and code 3 also gives 16. The words come out in the order the memory delivered them, with rd_valid_o high for one cycle per word.
- R4: With cfg_wait_early_i=0, a word is captured at a rising memory clock edge only if WAIT is high (inactive) at that edge. rd_valid_o is high in the controller cycle that follows the high phase of that edge.
- R5: With cfg_wait_early_i=1, a word is captured at an edge only if WAIT was high at the previous rising edge of the same burst. No word is ever captured at the first edge of the data phase.
- R6: During an asynchronous write, the memory clock stays low for the whole time chip enable is low. The write data and address are driven, and write enable is low for max(T_WC_CYC-SETUP_CYC-1,1) cycles.
- R7: While write enable is low, address-valid is high if ADV_PULSE=1, because the address was latched by a pulse before write enable fell. It is held low if ADV_PULSE=0.
- R8: Chip enable stays low for at least T_WC_CYC controller cycles in every write.
- R9: Chip enable is high for at least GAP_CYC cycles between any two operations, so a write and a read never share one low period of chip enable.
- R10: With aligned timing, chip enable never rises after an edge at which WAIT was active, unless the burst timed out.
- R11: When WAIT is active at timeout_lim_i consecutive edges, timeout_o is high for one cycle, in the cycle after the last of those edges. The burst then ends with no further words and chip enable goes high.
- R12: The write byte mask req_be_i (bit 0 for the low byte) is driven inverted on mem_be_no while chip enable is low for the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wait_early_i | input | 1 | 1: WAIT leads the wait cycles by one edge; 0: WAIT is aligned with them |
| timeout_lim_i | input | TO_W | Number of consecutive active WAIT edges that ends a burst |
| req_valid_i | input | 1 | Request strobe, accepted while ready is high |
| req_ready_o | output | 1 | Controller is idle |
| req_write_i | input | 1 | 1 = asynchronous write, 0 = burst read |
| req_addr_i | input | ADDR_W | Word address |
| req_len_i | input | 2 | Burst length code |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | DATA_W/8 | Write byte mask, active high |
| rd_data_o | output | DATA_W | Read word |
| rd_valid_o | output | 1 | One pulse per read word |
| timeout_o | output | 1 | WAIT timeout pulse |
| mem_clk_o | output | 1 | Memory clock |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_adv_no | output | 1 | Address valid, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_be_no | output | DATA_W/8 | Byte enables, active low |
| mem_dq_o | output | DATA_W | Write data to the pads |
| mem_dq_oe_o | output | 1 | Write data drive enable |
| mem_dq_i | input | DATA_W | Read data from the pads |
| mem_wait_ni | input | 1 | Shared WAIT, active low |

## Verification
The memory model drives WAIT and data on the falling controller edge of the memory clock's low phase. The controller samples them at the end of the following high phase. Each expected word is therefore due on rd_valid_o in the next controller cycle. The bench checks every cycle that rd_valid_o is high exactly when a word is due and low otherwise. The timeout pulse is due in the cycle after the limiting edge, and the bench checks this against the number of sampling phases the model has counted. The write pulse widths, the address phase and the chip-enable gaps are measured in whole controller cycles at the falling edge and compared with their exact values.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_GAP
  } psram_st_e;

  localparam int unsigned WORDS_W = 5;

  function automatic logic [WORDS_W-1:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return WORDS_W'(4);
      2'd1:    return WORDS_W'(8);
      default: return WORDS_W'(16);
    endcase
  endfunction

  function automatic logic is_wr_state(input psram_st_e s);
    return (s == ST_WR_SETUP) || (s == ST_WR_PULSE) || (s == ST_WR_HOLD);
  endfunction

endpackage

// File: rtl/psram_clk_gen.sv
// Half-rate memory clock; parks low whenever not running.
module psram_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mem_clk_o,
  output logic high_o
);
  logic clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    clk_q <= 1'b0;
    else if (run_i) clk_q <= ~clk_q;
    else            clk_q <= 1'b0;
  end

  assign mem_clk_o = clk_q;
  assign high_o    = run_i & clk_q;
endmodule

// File: rtl/psram_wait_track.sv
// Decides per memory edge whether a word is present and tracks stall length.
module psram_wait_track #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sample_i,
  input  logic             wait_act_i,
  input  logic             early_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             word_ok_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic             prev_q;
  logic [CNT_W-1:0] run_q, run_inc;

  assign run_inc   = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
  assign expire_o  = sample_i & wait_act_i & (run_inc >= lim_i);
  // timeout wins over a word on the same edge
  assign word_ok_o = sample_i & ~expire_o & (early_i ? ~prev_q : ~wait_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      run_q  <= '0;
    end else if (start_i) begin
      prev_q <= 1'b1;
      run_q  <= '0;
    end else if (sample_i) begin
      prev_q <= wait_act_i;
      run_q  <= wait_act_i ? run_inc : '0;
    end
  end
endmodule

// File: rtl/psram_dwell.sv
// Loadable down counter; load has priority over decrement.
module psram_dwell #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/psram_mixed_ctrl.sv
module psram_mixed_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned T_WC_CYC  = 6,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned GAP_CYC   = 2,
  parameter int unsigned TO_W      = 8,
  parameter bit          ADV_PULSE = 1'b1,
  localparam int unsigned BE_W     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wait_early_i,
  input  logic [TO_W-1:0]   timeout_lim_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_len_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              timeout_o,
  output logic              mem_clk_o,
  output logic              mem_ce_no,
  output logic              mem_adv_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_wait_ni
);
  localparam int unsigned WE_CYC = (T_WC_CYC > SETUP_CYC + 1) ? T_WC_CYC - SETUP_CYC - 1 : 1;
  localparam int unsigned PH_M1  = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int unsigned PH_MAX = (PH_M1 > GAP_CYC) ? PH_M1 : GAP_CYC;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1) + 1;

  psram_st_e st_q, st_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q, timeout_q;

  logic            clk_run, clk_high, data_sample;
  logic            word_ok, expire, trk_start;
  logic            ph_load, ph_last;
  logic [PH_W-1:0] ph_val;
  logic            wc_load, wc_last;
  logic            adv_wr;

  assign clk_run     = (st_q == ST_RD_ADDR) || (st_q == ST_RD_DATA);
  assign data_sample = clk_high && (st_q == ST_RD_DATA);

  psram_clk_gen u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (clk_run),
    .mem_clk_o(mem_clk_o),
    .high_o   (clk_high)
  );

  psram_wait_track #(.CNT_W(TO_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (trk_start),
    .sample_i  (data_sample),
    .wait_act_i(~mem_wait_ni),
    .early_i   (cfg_wait_early_i),
    .lim_i     (timeout_lim_i),
    .word_ok_o (word_ok),
    .expire_o  (expire)
  );

  psram_dwell #(.W(PH_W)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ph_load),
    .val_i (ph_val),
    .dec_i (1'b1),
    .last_o(ph_last)
  );

  psram_dwell #(.W(WORDS_W)) u_words (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wc_load),
    .val_i (burst_words(req_len_i)),
    .dec_i (word_ok),
    .last_o(wc_last)
  );

  // address-valid level while the write strobe is low
  generate
    if (ADV_PULSE) begin : g_adv_pulse
      assign adv_wr = 1'b1;
    end else begin : g_adv_hold
      assign adv_wr = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d      = st_q;
    ph_load   = 1'b0;
    ph_val    = '0;
    wc_load   = 1'b0;
    trk_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_write_i) begin
            st_d    = ST_WR_SETUP;
            ph_load = 1'b1;
            ph_val  = PH_W'(SETUP_CYC);
          end else begin
            st_d    = ST_RD_ADDR;
            wc_load = 1'b1;
          end
        end
      end
      ST_RD_ADDR: begin
        if (clk_high) begin
          st_d      = ST_RD_DATA;
          trk_start = 1'b1;
        end
      end
      ST_RD_DATA: begin
        if (expire || (word_ok && wc_last)) begin
          st_d    = ST_GAP;
          ph_load = 1'b1;
          ph_val  = PH_W'(GAP_CYC);
        end
      end
      ST_WR_SETUP: begin
        if (ph_last) begin
          st_d    = ST_WR_PULSE;
          ph_load = 1'b1;
          ph_val  = PH_W'(WE_CYC);
        end
      end
      ST_WR_PULSE: begin
        if (ph_last) begin
          st_d    = ST_WR_HOLD;
          ph_load = 1'b1;
          ph_val  = PH_W'(1);
        end
      end
      ST_WR_HOLD: begin
        if (ph_last) begin
          st_d    = ST_GAP;
          ph_load = 1'b1;
          ph_val  = PH_W'(GAP_CYC);
        end
      end
      ST_GAP: begin
        if (ph_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      timeout_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      rd_valid_q <= word_ok;
      timeout_q  <= expire;
      if (word_ok) rd_data_q <= mem_dq_i;
      if (st_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
    end
  end

  always_comb begin
    mem_ce_no   = 1'b1;
    mem_adv_no  = 1'b1;
    mem_we_no   = 1'b1;
    mem_oe_no   = 1'b1;
    mem_be_no   = '1;
    mem_dq_oe_o = 1'b0;
    case (st_q)
      ST_RD_ADDR: begin
        mem_ce_no  = 1'b0;
        mem_adv_no = 1'b0;
        mem_be_no  = '0;
      end
      ST_RD_DATA: begin
        mem_ce_no = 1'b0;
        mem_oe_no = 1'b0;
        mem_be_no = '0;
      end
      ST_WR_SETUP: begin
        mem_ce_no   = 1'b0;
        mem_adv_no  = 1'b0;
        mem_be_no   = ~be_q;
        mem_dq_oe_o = 1'b1;
      end
      ST_WR_PULSE: begin
        mem_ce_no   = 1'b0;
        mem_adv_no  = adv_wr;
        mem_we_no   = 1'b0;
        mem_be_no   = ~be_q;
        mem_dq_oe_o = 1'b1;
      end
      ST_WR_HOLD: begin
        mem_ce_no   = 1'b0;
        mem_adv_no  = adv_wr;
        mem_be_no   = ~be_q;
        mem_dq_oe_o = is_wr_state(st_q);
      end
      default: ;
    endcase
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rd_data_o   = rd_data_q;
  assign rd_valid_o  = rd_valid_q;
  assign timeout_o   = timeout_q;

endmodule

// File: rtl/psram_mixed_ctrl_chk.sv
module psram_mixed_ctrl_chk #(
  parameter int unsigned T_WC_CYC  = 6,
  parameter int unsigned GAP_CYC   = 2,
  parameter bit          ADV_PULSE = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_wait_early_i,
  input logic mem_clk_o,
  input logic mem_ce_no,
  input logic mem_adv_no,
  input logic mem_we_no,
  input logic mem_oe_no,
  input logic mem_dq_oe_o,
  input logic mem_wait_ni,
  input logic rd_valid_o,
  input logic timeout_o
);
  logic [7:0] wr_len_q, gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_len_q <= '0;
      gap_q    <= 8'hFF;
    end else begin
      if (!mem_ce_no && mem_dq_oe_o) wr_len_q <= (wr_len_q == 8'hFF) ? wr_len_q : wr_len_q + 8'd1;
      else if (mem_ce_no)            wr_len_q <= '0;
      if (mem_ce_no) gap_q <= (gap_q == 8'hFF) ? gap_q : gap_q + 8'd1;
      else           gap_q <= '0;
    end
  end

  p_valid_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!mem_oe_no && mem_clk_o));

  p_clk_static_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && mem_dq_oe_o) |-> (!mem_clk_o && $stable(mem_clk_o)));

  p_adv_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no) |-> (mem_adv_no == ADV_PULSE));

  p_wr_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_ce_no) && $past(mem_dq_oe_o)) |-> (32'(wr_len_q) >= T_WC_CYC));

  p_ce_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (32'(gap_q) >= GAP_CYC));

  p_no_mix_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> (mem_dq_oe_o == $past(mem_dq_oe_o)));

  p_ce_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_wait_early_i && !mem_ce_no && !mem_oe_no && mem_clk_o && !mem_wait_ni)
      |=> (!mem_ce_no || timeout_o));

  p_to_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  p_to_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> mem_ce_no);

endmodule

bind psram_mixed_ctrl psram_mixed_ctrl_chk #(
  .T_WC_CYC (T_WC_CYC),
  .GAP_CYC  (GAP_CYC),
  .ADV_PULSE(ADV_PULSE)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_wait_early_i(cfg_wait_early_i),
  .mem_clk_o       (mem_clk_o),
  .mem_ce_no       (mem_ce_no),
  .mem_adv_no      (mem_adv_no),
  .mem_we_no       (mem_we_no),
  .mem_oe_no       (mem_oe_no),
  .mem_dq_oe_o     (mem_dq_oe_o),
  .mem_wait_ni     (mem_wait_ni),
  .rd_valid_o      (rd_valid_o),
  .timeout_o       (timeout_o)
);

// File: tb/psram_mixed_ctrl_tb_top.sv
module psram_mixed_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int BW = DW / 8;
  localparam int T_WC = 6;
  localparam int SETUP = 2;
  localparam int GAP = 2;
  localparam bit ADVP = 1'b1;
  localparam int WE_EXP = T_WC - SETUP - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_early = 1'b0;
  logic [7:0] to_lim = 8'd200;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic req_ready, rd_valid, timeout;
  logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i = '0;
  logic mem_clk, ce_n, adv_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] be_n;
  logic wait_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_mixed_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_WC_CYC(T_WC), .SETUP_CYC(SETUP),
                     .GAP_CYC(GAP), .TO_W(8), .ADV_PULSE(ADVP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wait_early_i(cfg_early), .timeout_lim_i(to_lim),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .timeout_o(timeout),
    .mem_clk_o(mem_clk), .mem_ce_no(ce_n), .mem_adv_no(adv_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_addr_o(mem_addr), .mem_be_no(be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i), .mem_wait_ni(wait_n)
  );

  int n_chk = 0, n_fail = 0;

  // stimulus-side model configuration (written by tasks only)
  logic [63:0] wait_pat = '0;
  int exp_base = 0, exp_n = 0;

  // monitor / memory model state (written by the monitor only)
  int edge_i = 0, sent = 0;
  bit nxt_v = 0, pend_chk = 0, pend_v = 0;
  logic [DW-1:0] nxt_d = '0, pend_d = '0;
  int mdl_err = 0, n_words = 0, n_samples = 0;
  int adr_cyc = 0, rd_clk_bad = 0, rd_be_bad = 0;
  logic [AW-1:0] adr_seen = '0;
  int wr_cyc = 0, wr_we = 0, wr_clk_bad = 0, wr_adv_bad = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_dq = '0;
  logic [BW-1:0] wr_be = '0;
  int hi_run = 0, min_gap = 1000, mix_bad = 0, ce_wait_bad = 0;
  bit seen_low = 0;
  int to_cnt = 0, to_samples = -1;
  bit p_ce = 1, p_oe = 0, p_clk = 0, p_wait = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_v, rd_ph, act, dlv;
      exp_v = pend_chk ? pend_v : 1'b0;
      if (rd_valid !== exp_v || (exp_v && rd_data !== pend_d)) mdl_err++;
      if (rd_valid) n_words++;
      pend_chk = 0;
      rd_ph = !ce_n && !oe_n;
      if (!ce_n && !adv_n && oe_n && !dq_oe) begin
        adr_cyc++; adr_seen = mem_addr; edge_i = 0; sent = 0;
      end
      if (rd_ph && mem_clk) begin
        n_samples++; pend_chk = 1; pend_v = nxt_v; pend_d = nxt_d;
      end
      if (!ce_n && !dq_oe && !p_ce && !p_oe && mem_clk == p_clk) rd_clk_bad++;
      if (!ce_n && !dq_oe && be_n != '0) rd_be_bad++;
      if (!ce_n && dq_oe) begin
        wr_cyc++;
        if (mem_clk) wr_clk_bad++;
        if (!we_n) begin
          wr_we++;
          if (adv_n != ADVP) wr_adv_bad++;
          wr_addr = mem_addr; wr_dq = mem_dq_o; wr_be = be_n;
        end
      end
      if (ce_n) begin
        if (!p_ce && !p_wait && !timeout && !cfg_early) ce_wait_bad++;
        hi_run++;
      end else begin
        if (p_ce) begin
          if (seen_low && hi_run < min_gap) min_gap = hi_run;
          seen_low = 1; hi_run = 0;
        end else if (dq_oe != p_oe) mix_bad++;
      end
      if (timeout) begin
        to_cnt++;
        if (to_samples < 0) to_samples = n_samples;
      end
      p_ce = ce_n; p_oe = dq_oe; p_clk = mem_clk; p_wait = wait_n;
      // prepare WAIT and data for the next rising memory clock edge
      if (rd_ph && !mem_clk) begin
        act = (edge_i < 64) ? wait_pat[edge_i] : 1'b0;
        if (cfg_early) dlv = (edge_i > 0) && !((edge_i - 1 < 64) ? wait_pat[edge_i-1] : 1'b0);
        else           dlv = !act;
        if (sent >= exp_n) dlv = 0;
        wait_n = !act;
        nxt_v = dlv;
        if (dlv) begin
          nxt_d = DW'(exp_base + sent * 3);
          mem_dq_i = nxt_d;
          sent++;
        end
        edge_i++;
      end else if (!rd_ph) begin
        wait_n = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [1:0] len,
                       input logic [DW-1:0] d, input logic [BW-1:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_op();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ce_n && adv_n && we_n && oe_n, "R1 strobes idle high", {ce_n, adv_n, we_n, oe_n}, 15);
    chk(!mem_clk, "R1 memory clock low", mem_clk, 0);
    chk(req_ready && !rd_valid && !timeout, "R1 ready/valid/timeout", {req_ready, rd_valid, timeout}, 4);
  endtask

  task automatic t_read(input string tag, input bit early, input logic [1:0] len, input int words,
                        input logic [63:0] pat, input int samples, input logic [AW-1:0] a);
    int e0, w0, s0, a0, cb0, bb0, cw0;
    cfg_early = early; wait_pat = pat; exp_base = int'(a[11:0]) * 7; exp_n = words;
    e0 = mdl_err; w0 = n_words; s0 = n_samples; a0 = adr_cyc;
    cb0 = rd_clk_bad; bb0 = rd_be_bad; cw0 = ce_wait_bad;
    issue(1'b0, a, len, '0, '0);
    finish_op();
    chk(n_words - w0 == words, {tag, " word count"}, n_words - w0, words);
    chk(mdl_err == e0, {tag, " valid/data timing"}, mdl_err - e0, 0);
    chk(n_samples - s0 == samples, {tag, " edges used"}, n_samples - s0, samples);
    chk(adr_cyc - a0 == 2 && adr_seen == a, "R2 address phase", adr_cyc - a0, 2);
    chk(rd_clk_bad == cb0 && rd_be_bad == bb0, "R2 clock toggle / byte enables", rd_clk_bad - cb0, 0);
    chk(ce_wait_bad == cw0, "R10 chip enable held during WAIT", ce_wait_bad - cw0, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    int c0, w0, k0, v0;
    c0 = wr_cyc; w0 = wr_we; k0 = wr_clk_bad; v0 = wr_adv_bad;
    issue(1'b1, a, 2'd0, d, be);
    finish_op();
    chk(wr_clk_bad == k0, "R6 clock static in write", wr_clk_bad - k0, 0);
    chk(wr_we - w0 == WE_EXP, "R6 write strobe width", wr_we - w0, WE_EXP);
    chk(wr_addr == a && wr_dq == d, "R6 write address/data", wr_dq, d);
    chk(wr_adv_bad == v0, "R7 address-valid level during strobe", wr_adv_bad - v0, 0);
    chk(wr_cyc - c0 >= T_WC, "R8 write cycle length", wr_cyc - c0, T_WC);
    chk(wr_be == ~be, "R12 byte enables", wr_be, ~be);
  endtask

  task automatic t_back_to_back();
    int m0;
    m0 = mix_bad;
    cfg_early = 1'b0; wait_pat = '0; exp_base = 0; exp_n = 4;
    issue(1'b1, 22'h00ABC, 2'd0, 16'h1234, 2'b11);
    issue(1'b0, 22'h00000, 2'd0, '0, '0);
    finish_op();
    chk(min_gap >= GAP, "R9 chip enable gap", min_gap, GAP);
    chk(mix_bad == m0, "R9 no mode change under one chip enable", mix_bad - m0, 0);
  endtask

  task automatic t_timeout();
    int w0, t0, s0;
    cfg_early = 1'b0; wait_pat = '1; exp_base = 0; exp_n = 4; to_lim = 8'd5;
    w0 = n_words; t0 = to_cnt; s0 = n_samples; to_samples = -1;
    issue(1'b0, 22'h00100, 2'd0, '0, '0);
    finish_op();
    chk(to_cnt - t0 == 1, "R11 single timeout pulse", to_cnt - t0, 1);
    chk(to_samples - s0 == 5, "R11 timeout after limit edges", to_samples - s0, 5);
    chk(n_words == w0, "R11 no words after timeout", n_words - w0, 0);
    chk(n_samples - s0 == 5, "R11 burst ended", n_samples - s0, 5);
    to_lim = 8'd200;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read("R3 R4 len4 aligned", 1'b0, 2'd0, 4, 64'h0, 4, 22'h01230);
    t_read("R4 len8 aligned with waits", 1'b0, 2'd1, 8, 64'h73, 13, 22'h02468);
    t_read("R5 len16 early with waits", 1'b1, 2'd2, 16, 64'h83, 20, 22'h13579);
    t_read("R5 len4 early first edge", 1'b1, 2'd0, 4, 64'h0, 5, 22'h00042);
    t_read("R3 code3 gives 16", 1'b0, 2'd3, 16, 64'h0, 16, 22'h3FFF0);
    t_write(22'h12345, 16'hA5C3, 2'b01);
    t_write(22'h2AAAA, 16'h0F0F, 2'b10);
    t_back_to_back();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule